// File: doc/BRIEF.md
# Dual 9-bit Transparent Latch with Guarded Output Enables

The block holds two independent groups of nine data bits, called group A and group B. Each group has its own active-high load enable and its own active-low output enable. While a group's load enable is high, the stored word follows the input word. When the load enable drops, the group keeps the last word it loaded. The output enable controls only whether the stored word is driven. Loading continues while the outputs are off.

The latch is built as a level-sensitive register stage that is clocked by a fast sampling clock, so its behaviour can be checked cycle by cycle. Each group's output is a data word plus a drive flag. A pad ring outside the block turns these into three-state pins.

After reset, each group keeps its drive flag low until its output-enable pin has been sampled inactive (high) and then active (low). This protects a card that is inserted while the bus is live. The guard is tracked separately for each group.

Top module: `twin_byte_latch`

## Requirements
- R1: While `rst` is high at a rising edge, both data outputs become all zeros and both drive flags become 0 after that edge.
- R2: If a group's load enable is sampled high at a rising edge, that group's data output equals the input word sampled at that edge once the edge has passed.
- R3: If a group's load enable is sampled low at a rising edge, that group's data output is unchanged by that edge.
- R4: Once a group's guard is armed, sampling its output enable low (active) at an edge sets its drive flag to 1 after that edge.
- R5: Sampling a group's output enable high (inactive) at an edge clears its drive flag to 0 after that edge.
- R6: A group whose drive flag is 0 still loads new data according to R2. The loaded word appears on its data output when the group is driven again.
- R7: After reset, a group's drive flag stays 0 until its output enable has been sampled high at some edge and then low at a later edge. This holds even if the output enable was low throughout and after reset.
- R8: Each group has its own guard, load path and drive path. Stimulus on one group never changes the other group's outputs.
- R9: Once a group's guard is armed, it stays armed until the next reset, so later output-enable toggles need no new high-to-low sequence before the first low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| a_din | input | 9 | Group A input word |
| a_load | input | 1 | Group A load enable, active high |
| a_oe_n | input | 1 | Group A output enable, active low |
| b_din | input | 9 | Group B input word |
| b_load | input | 1 | Group B load enable, active high |
| b_oe_n | input | 1 | Group B output enable, active low |
| a_dout | output | 9 | Group A stored word |
| a_drive | output | 1 | Group A drive flag (1 = pins driven, 0 = high impedance) |
| b_dout | output | 9 | Group B stored word |
| b_drive | output | 1 | Group B drive flag |

## Verification
The assertions check on every cycle that loading follows the enable (R2), that holding keeps the word stable (R3), that an inactive enable always clears the drive flag (R5), that no drive occurs before an inactive sample has been seen (R7), and that an armed guard never disarms (R9). Only the bench scenarios can show the following. The guard stays closed when the enable is held low through reset. Data loaded while the outputs are off surfaces later (R6). Traffic on one group leaves the other untouched (R8). A reset in mid-run closes the guard again. A behavioural reference model compared on every clock covers the cycles between these scenarios.

// File: rtl/twin_latch_pkg.sv
package twin_latch_pkg;
  localparam int unsigned DEF_WORD_W = 9;
  localparam int unsigned NUM_GROUPS = 2;

  typedef enum logic [1:0] {
    GUARD_IDLE  = 2'd0,
    GUARD_SEEN  = 2'd1,
    GUARD_ARMED = 2'd2
  } guard_state_e;
endpackage

// File: rtl/latch_word_store.sv
module latch_word_store #(
  parameter int unsigned WORD_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= din;
  end

  assert_load_follows_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> (q == $past(din)));

  assert_hold_stable_R3: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(q));
endmodule

// File: rtl/oe_power_guard.sv
module oe_power_guard
  import twin_latch_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic oe_n,
  output logic drive,
  output logic armed
);
  guard_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      GUARD_IDLE:  if (oe_n)  state_d = GUARD_SEEN;
      GUARD_SEEN:  if (!oe_n) state_d = GUARD_ARMED;
      GUARD_ARMED: state_d = GUARD_ARMED;
      default:     state_d = GUARD_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= GUARD_IDLE;
      drive   <= 1'b0;
    end else begin
      state_q <= state_d;
      drive   <= (state_d == GUARD_ARMED) && !oe_n;
    end
  end

  assign armed = (state_q == GUARD_ARMED);

  assert_inactive_clears_R5: assert property (@(posedge clk) disable iff (rst)
    oe_n |=> !drive);

  assert_no_early_drive_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == GUARD_IDLE) |=> !drive);

  assert_armed_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    armed |=> armed);
endmodule

// File: rtl/twin_byte_latch.sv
module twin_byte_latch
  import twin_latch_pkg::*;
#(
  parameter int unsigned WORD_W = DEF_WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] a_din,
  input  logic              a_load,
  input  logic              a_oe_n,
  input  logic [WORD_W-1:0] b_din,
  input  logic              b_load,
  input  logic              b_oe_n,
  output logic [WORD_W-1:0] a_dout,
  output logic              a_drive,
  output logic [WORD_W-1:0] b_dout,
  output logic              b_drive
);
  localparam int unsigned NG = NUM_GROUPS;

  logic [WORD_W-1:0] din_v  [NG];
  logic [WORD_W-1:0] q_v    [NG];
  logic              load_v [NG];
  logic              oen_v  [NG];
  logic              drv_v  [NG];
  logic              arm_v  [NG];

  assign din_v[0]  = a_din;
  assign din_v[1]  = b_din;
  assign load_v[0] = a_load;
  assign load_v[1] = b_load;
  assign oen_v[0]  = a_oe_n;
  assign oen_v[1]  = b_oe_n;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    latch_word_store #(.WORD_W(WORD_W)) u_store (
      .clk  (clk),
      .rst  (rst),
      .load (load_v[g]),
      .din  (din_v[g]),
      .q    (q_v[g])
    );

    oe_power_guard u_guard (
      .clk   (clk),
      .rst   (rst),
      .oe_n  (oen_v[g]),
      .drive (drv_v[g]),
      .armed (arm_v[g])
    );

    assert_drive_needs_arm_R4: assert property (@(posedge clk) disable iff (rst)
      drv_v[g] |-> arm_v[g]);
  end

  assign a_dout  = q_v[0];
  assign b_dout  = q_v[1];
  assign a_drive = drv_v[0];
  assign b_drive = drv_v[1];

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (!a_drive && !b_drive && a_dout == '0 && b_dout == '0));
endmodule

// File: tb/sim_twin_byte_latch.sv
module sim_twin_byte_latch;
  localparam int W = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a_din = '0, b_din = '0;
  logic a_load = 1'b0, b_load = 1'b0;
  logic a_oe_n = 1'b0, b_oe_n = 1'b0;
  logic [W-1:0] a_dout, b_dout;
  logic a_drive, b_drive;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  twin_byte_latch #(.WORD_W(W)) u0 (
    .clk(clk), .rst(rst),
    .a_din(a_din), .a_load(a_load), .a_oe_n(a_oe_n),
    .b_din(b_din), .b_load(b_load), .b_oe_n(b_oe_n),
    .a_dout(a_dout), .a_drive(a_drive),
    .b_dout(b_dout), .b_drive(b_drive)
  );

  // Behavioural reference: per group, stored word plus a history of
  // output-enable samples since reset.
  int m_word [2];
  int m_drive [2];
  int m_saw_high [2];
  int m_armed [2];

  always @(posedge clk) begin
    int ld [2];
    int dn [2];
    int on [2];
    ld[0] = a_load; ld[1] = b_load;
    dn[0] = a_din;  dn[1] = b_din;
    on[0] = a_oe_n; on[1] = b_oe_n;
    for (int g = 0; g < 2; g++) begin
      if (rst) begin
        m_word[g] = 0; m_drive[g] = 0; m_saw_high[g] = 0; m_armed[g] = 0;
      end else begin
        if (ld[g] != 0) m_word[g] = dn[g];
        if (on[g] == 0 && m_saw_high[g] != 0) m_armed[g] = 1;
        if (on[g] != 0) m_saw_high[g] = 1;
        m_drive[g] = (m_armed[g] != 0 && on[g] == 0) ? 1 : 0;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the model (R2 R3 data, R4 R5 R7 drive).
  always @(negedge clk) begin
    if (!finished) begin
      check("R2/R3 a_dout", int'(a_dout), m_word[0]);
      check("R2/R3 b_dout", int'(b_dout), m_word[1]);
      check("R4/R5/R7 a_drive", int'(a_drive), m_drive[0]);
      check("R4/R5/R7 b_drive", int'(b_drive), m_drive[1]);
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  initial begin
    // R7: enables held low through reset
    a_load = 1'b1; b_load = 1'b1; a_din = 9'h0AA; b_din = 9'h155;
    repeat (3) tick();
    check("R1 a_dout", int'(a_dout), 0);
    check("R1 b_dout", int'(b_dout), 0);
    check("R1 a_drive", int'(a_drive), 0);
    check("R1 b_drive", int'(b_drive), 0);
    rst = 1'b0; b_load = 1'b0;
    a_din = 9'h1A5;
    tick();
    check("R2 a_dout load", int'(a_dout), 'h1A5);
    check("R7 a_drive held off", int'(a_drive), 0);
    check("R8 b_dout untouched", int'(b_dout), 0);
    a_din = 9'h0F0;
    tick();
    check("R2 a_dout follows", int'(a_dout), 'h0F0);
    a_load = 1'b0; a_din = 9'h111;
    tick();
    check("R3 a_dout hold", int'(a_dout), 'h0F0);
    a_din = 9'h022;
    tick();
    check("R3 a_dout hold again", int'(a_dout), 'h0F0);
    check("R7 a_drive still off", int'(a_drive), 0);
    // arm group A
    a_oe_n = 1'b1;
    tick();
    check("R5 a_drive off", int'(a_drive), 0);
    a_oe_n = 1'b0;
    tick();
    check("R4 a_drive on", int'(a_drive), 1);
    check("R8 b_drive stays off", int'(b_drive), 0);
    // load while disabled
    a_oe_n = 1'b1; a_load = 1'b1; a_din = 9'h155;
    tick();
    check("R5 a_drive off", int'(a_drive), 0);
    check("R6 a_dout loads while off", int'(a_dout), 'h155);
    a_load = 1'b0; a_oe_n = 1'b0;
    tick();
    check("R9 a_drive re-enable", int'(a_drive), 1);
    check("R6 a_dout surfaces", int'(a_dout), 'h155);
    // group B
    b_oe_n = 1'b1;
    tick();
    b_oe_n = 1'b0; b_load = 1'b1; b_din = 9'h1FF;
    tick();
    check("R4 b_drive on", int'(b_drive), 1);
    check("R2 b_dout", int'(b_dout), 'h1FF);
    check("R8 a_dout untouched", int'(a_dout), 'h155);
    b_load = 1'b0;
    // R9: repeated toggles keep guard armed
    for (int i = 0; i < 3; i++) begin
      a_oe_n = 1'b1; tick();
      a_oe_n = 1'b0; tick();
      check("R9 a_drive after toggle", int'(a_drive), 1);
    end
    // mid-run reset closes guards again
    rst = 1'b1;
    tick();
    rst = 1'b0;
    tick();
    check("R7 a_drive after re-reset", int'(a_drive), 0);
    check("R7 b_drive after re-reset", int'(b_drive), 0);
    check("R1 a_dout after re-reset", int'(a_dout), 0);
    repeat (2) tick();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule